// File: doc/BRIEF.md
# Multi-Rate DRAM Refresh and Scrub Scheduler

This block decides which DRAM row to refresh, and when. It keeps one class bit per row. A row is either fast, meaning it is refreshed once per base retention period, or slow, meaning it is refreshed only on every Nth pass of the refresh walk. N is a configured multiple between 4 and 8. All timing is counted in scaled time ticks.

The class table is loaded from a retention profile while the scheduler is disabled. The ECC path reports rows that showed an error, and each reported row is moved to the fast class on the fly. It stays fast until a new profile is written.

A second, much slower timer starts a scrub sweep. The sweep issues one read per row so that the ECC path inspects the whole array. Refresh and scrub commands share a single valid/ready command port. The busy output tells the request path to hold off normal traffic while a command is outstanding.

Top module: `refresh_sched`

## Requirements
- R1: Reset state:
  - every row is fast;
  - no command is offered and busy is low;
  - both counters read zero.
- R2: Refresh slots and round-robin walk:
  - A refresh slot ends every `BASE_TICKS/ROWS` ticks (`tick_i` high while `en_i` is high).
  - Each slot handles one row, starting at row 0 and walking in increasing order, wrapping at `ROWS-1`.
  - A fast row is refreshed in every pass.
- R3: Slow-row passes:
  - Pass numbers count from 0 after reset, and each wrap of the walk advances the pass.
  - A slow row (class bit 1) is refreshed only in passes whose number modulo N is 0.
  - N is `slow_mult_i` clamped to the range 4..8, sampled when the walk wraps.
- R4: Profile writes:
  - While `en_i` is low, `prof_we_i` writes `prof_slow_i` as the class of row `prof_row_i` (1 = slow, 0 = fast).
  - While `en_i` is high, such writes are ignored.
- R5: ECC promotion:
  - `ecc_err_i` makes row `ecc_row_i` fast from that cycle on.
  - A report in the same cycle as that row's slot decision already counts as fast for that decision.
  - `promote_cnt_o` increments only when the row was slow.
- R6: Scrub sweeps:
  - Every `SCRUB_TICKS` ticks a scrub sweep starts.
  - A sweep offers one scrub read per row, rows 0 to `ROWS-1` in order.
- R7: Refresh priority:
  - When a refresh slot is pending and the command port is free, the refresh is issued ahead of any scrub read.
  - An interrupted sweep continues from the row where it stopped.
- R8: Command handshake:
  - A command is accepted when `cmd_valid_o` and `cmd_ready_i` are both high.
  - While valid and not ready, `cmd_row_o` and `cmd_scrub_o` hold steady.
  - `cmd_scrub_o` is 1 for a scrub read and 0 for a refresh.
- R9: `busy_o` is high exactly while a command is offered.
- R10: `refresh_cnt_o` counts accepted refresh commands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Scheduler enable; low permits profile writes |
| tick_i | input | 1 | Scaled time tick, one cycle per tick |
| slow_mult_i | input | 4 | Slow-class period multiple, clamped to 4..8 |
| prof_we_i | input | 1 | Profile write strobe |
| prof_row_i | input | $clog2(ROWS) | Profile row address |
| prof_slow_i | input | 1 | Profile class bit, 1 = slow |
| ecc_err_i | input | 1 | ECC error report strobe |
| ecc_row_i | input | $clog2(ROWS) | Row of the reported error |
| cmd_valid_o | output | 1 | Command offered |
| cmd_ready_i | input | 1 | Command taken by the device side |
| cmd_row_o | output | $clog2(ROWS) | Command row address |
| cmd_scrub_o | output | 1 | 1 = scrub read, 0 = refresh |
| busy_o | output | 1 | Hold off normal requests |
| refresh_cnt_o | output | CNT_W | Accepted refresh commands |
| promote_cnt_o | output | CNT_W | Slow-to-fast promotions |

## Verification
The bench builds the block with the following parameters:

| Parameter | Value | Effect |
|-----------|-------|--------|
| `ROWS` | 8 | short walk |
| `BASE_TICKS` | 32 | a slot every 4 ticks |
| `SCRUB_TICKS` | 40 | frequent sweeps |
| `CNT_W` | 16 | counter width |

With these values, whole multi-pass cycles at multiples 4 and 8, and the clamping of out-of-range settings, fit in a few hundred ticks. A sweep start falls on a slot boundary, so a stall of the command port can line up a pending refresh against a pending scrub read. An ECC report can also be placed on the exact tick that closes a slow row's skipped slot.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  typedef enum logic {
    CMD_REFRESH = 1'b0,
    CMD_SCRUB   = 1'b1
  } cmd_kind_e;

  // slow-class multiple limited to 4..8
  function automatic logic [3:0] clamp_mult(input logic [3:0] m);
    if (m < 4'd4) return 4'd4;
    if (m > 4'd8) return 4'd8;
    return m;
  endfunction

endpackage

// File: rtl/rate_table.sv
module rate_table #(
  parameter int ROWS  = 16,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             prof_we_i,
  input  logic [ROW_W-1:0] prof_row_i,
  input  logic             prof_slow_i,
  input  logic             ecc_err_i,
  input  logic [ROW_W-1:0] ecc_row_i,
  input  logic [ROW_W-1:0] rd_row_i,
  output logic             rd_slow_o,
  output logic             promote_o
);

  logic [ROWS-1:0] slow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slow_q <= '0;
    end else begin
      if (!en_i && prof_we_i) slow_q[prof_row_i] <= prof_slow_i;
      // error report overrides a same-cycle profile write
      if (ecc_err_i) slow_q[ecc_row_i] <= 1'b0;
    end
  end

  // bypass: a report landing with the lookup is already seen as fast
  assign rd_slow_o = slow_q[rd_row_i] && !(ecc_err_i && (ecc_row_i == rd_row_i));
  assign promote_o = ecc_err_i && slow_q[ecc_row_i];

  // R5
  ecc_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_err_i |=> !slow_q[$past(ecc_row_i)]);

  // R4
  locked_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !ecc_err_i) |=> $stable(slow_q));

endmodule

// File: rtl/refresh_walker.sv
module refresh_walker
  import refresh_pkg::*;
#(
  parameter int ROWS       = 16,
  parameter int ROW_W      = $clog2(ROWS),
  parameter int SLOT_TICKS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [3:0]       mult_i,
  input  logic             busy_i,
  input  logic             row_slow_i,
  output logic             pend_o,
  output logic             take_o,
  output logic             issue_o,
  output logic [ROW_W-1:0] row_o
);

  localparam int SLOT_W = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_TICKS - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(ROWS - 1);

  logic [SLOT_W-1:0] slot_cnt_q;
  logic              slot_due_q;
  logic              slot_end;
  logic [ROW_W-1:0]  ptr_q;
  logic [2:0]        pass_q;
  logic [3:0]        n_eff;

  assign n_eff    = clamp_mult(mult_i);
  assign slot_end = en_i && tick_i && (slot_cnt_q == SLOT_LAST);
  assign pend_o   = slot_due_q || slot_end;
  assign take_o   = en_i && !busy_i && pend_o;
  assign issue_o  = take_o && (!row_slow_i || (pass_q == 3'd0));
  assign row_o    = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_cnt_q <= '0;
      slot_due_q <= 1'b0;
      ptr_q      <= '0;
      pass_q     <= '0;
    end else begin
      if (en_i && tick_i) slot_cnt_q <= slot_end ? '0 : slot_cnt_q + 1'b1;
      if (take_o)        slot_due_q <= 1'b0;
      else if (slot_end) slot_due_q <= 1'b1;
      if (take_o) begin
        ptr_q <= (ptr_q == ROW_LAST) ? '0 : ptr_q + 1'b1;
        if (ptr_q == ROW_LAST)
          pass_q <= ({1'b0, pass_q} >= (n_eff - 4'd1)) ? 3'd0 : pass_q + 3'd1;
      end
    end
  end

  // R2
  walk_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> (ptr_q == ROW_W'($past(ptr_q) + 1'b1)));

  // R3
  pass_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && (ptr_q == ROW_LAST)) |=> ({1'b0, pass_q} < $past(n_eff)));

endmodule

// File: rtl/scrub_walker.sv
module scrub_walker #(
  parameter int ROWS        = 16,
  parameter int ROW_W       = $clog2(ROWS),
  parameter int SCRUB_TICKS = 900000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             take_i,
  output logic             want_o,
  output logic [ROW_W-1:0] row_o
);

  localparam int SCRUB_W = (SCRUB_TICKS > 1) ? $clog2(SCRUB_TICKS) : 1;
  localparam logic [SCRUB_W-1:0] SCRUB_LAST = SCRUB_W'(SCRUB_TICKS - 1);
  localparam logic [ROW_W-1:0]   ROW_LAST   = ROW_W'(ROWS - 1);

  logic [SCRUB_W-1:0] cnt_q;
  logic               active_q;
  logic [ROW_W-1:0]   ptr_q;
  logic               start;

  assign start  = en_i && tick_i && (cnt_q == SCRUB_LAST);
  assign want_o = active_q;
  assign row_o  = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      ptr_q    <= '0;
    end else begin
      if (en_i && tick_i) cnt_q <= start ? '0 : cnt_q + 1'b1;
      if (take_i) ptr_q <= (ptr_q == ROW_LAST) ? '0 : ptr_q + 1'b1;
      if (take_i && (ptr_q == ROW_LAST)) active_q <= 1'b0;
      else if (start)                    active_q <= 1'b1;
    end
  end

  // R7
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(ptr_q));

  // R6
  sweep_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !active_q) |=> (active_q && (ptr_q == '0)));

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_pkg::*;
#(
  parameter int ROWS        = 16,
  parameter int BASE_TICKS  = 64,
  parameter int SCRUB_TICKS = 900000,
  parameter int CNT_W       = 16,
  localparam int ROW_W      = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [3:0]       slow_mult_i,
  input  logic             prof_we_i,
  input  logic [ROW_W-1:0] prof_row_i,
  input  logic             prof_slow_i,
  input  logic             ecc_err_i,
  input  logic [ROW_W-1:0] ecc_row_i,
  output logic             cmd_valid_o,
  input  logic             cmd_ready_i,
  output logic [ROW_W-1:0] cmd_row_o,
  output logic             cmd_scrub_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] refresh_cnt_o,
  output logic [CNT_W-1:0] promote_cnt_o
);

  localparam int SLOT_TICKS = BASE_TICKS / ROWS;

  logic             cmd_valid_q;
  logic [ROW_W-1:0] cmd_row_q;
  cmd_kind_e        cmd_kind_q;
  logic [CNT_W-1:0] refresh_cnt_q, promote_cnt_q;

  logic             ref_pend, ref_take, ref_issue, row_slow, promote;
  logic [ROW_W-1:0] ref_row, scr_row;
  logic             scr_want, scr_take;
  logic             accept;

  rate_table #(.ROWS(ROWS), .ROW_W(ROW_W)) u_table (
    .clk_i, .rst_ni, .en_i,
    .prof_we_i, .prof_row_i, .prof_slow_i,
    .ecc_err_i, .ecc_row_i,
    .rd_row_i  (ref_row),
    .rd_slow_o (row_slow),
    .promote_o (promote)
  );

  refresh_walker #(.ROWS(ROWS), .ROW_W(ROW_W), .SLOT_TICKS(SLOT_TICKS)) u_walker (
    .clk_i, .rst_ni, .en_i, .tick_i,
    .mult_i     (slow_mult_i),
    .busy_i     (cmd_valid_q),
    .row_slow_i (row_slow),
    .pend_o     (ref_pend),
    .take_o     (ref_take),
    .issue_o    (ref_issue),
    .row_o      (ref_row)
  );

  scrub_walker #(.ROWS(ROWS), .ROW_W(ROW_W), .SCRUB_TICKS(SCRUB_TICKS)) u_scrub (
    .clk_i, .rst_ni, .en_i, .tick_i,
    .take_i (scr_take),
    .want_o (scr_want),
    .row_o  (scr_row)
  );

  // a due slot blocks scrub even when the slot turns out to be skipped
  assign scr_take = en_i && !cmd_valid_q && scr_want && !ref_pend;
  assign accept   = cmd_valid_q && cmd_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_q   <= 1'b0;
      cmd_row_q     <= '0;
      cmd_kind_q    <= CMD_REFRESH;
      refresh_cnt_q <= '0;
      promote_cnt_q <= '0;
    end else begin
      if (ref_issue) begin
        cmd_valid_q <= 1'b1;
        cmd_row_q   <= ref_row;
        cmd_kind_q  <= CMD_REFRESH;
      end else if (scr_take) begin
        cmd_valid_q <= 1'b1;
        cmd_row_q   <= scr_row;
        cmd_kind_q  <= CMD_SCRUB;
      end else if (accept) begin
        cmd_valid_q <= 1'b0;
      end
      if (accept && (cmd_kind_q == CMD_REFRESH)) refresh_cnt_q <= refresh_cnt_q + 1'b1;
      if (promote) promote_cnt_q <= promote_cnt_q + 1'b1;
    end
  end

  assign cmd_valid_o   = cmd_valid_q;
  assign cmd_row_o     = cmd_row_q;
  assign cmd_scrub_o   = (cmd_kind_q == CMD_SCRUB);
  assign busy_o        = cmd_valid_q;
  assign refresh_cnt_o = refresh_cnt_q;
  assign promote_cnt_o = promote_cnt_q;

  // R8
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_q && !cmd_ready_i) |=>
      (cmd_valid_q && $stable(cmd_row_q) && $stable(cmd_kind_q)));

  // R7
  refresh_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_pend && en_i && !cmd_valid_q) |=> !(cmd_valid_q && (cmd_kind_q == CMD_SCRUB)));

  // R10
  refresh_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && (cmd_kind_q == CMD_REFRESH)) |=>
      (refresh_cnt_q == CNT_W'($past(refresh_cnt_q) + 1'b1)));

  // R5
  promote_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    promote |=> (promote_cnt_q == CNT_W'($past(promote_cnt_q) + 1'b1)));

endmodule

// File: tb/tb_refresh_sched.sv
`timescale 1ns/1ps
module tb_refresh_sched;

  localparam int ROWS  = 8;
  localparam int ROW_W = 3;
  localparam int BASE  = 32;
  localparam int SLOT  = BASE / ROWS;
  localparam int SCRUB = 40;
  localparam int CNT_W = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0, tick_i = 1'b0, prof_we_i = 1'b0, prof_slow_i = 1'b0;
  logic ecc_err_i = 1'b0, cmd_ready_i = 1'b1;
  logic [3:0] slow_mult_i = 4'd4;
  logic [ROW_W-1:0] prof_row_i = '0, ecc_row_i = '0;
  logic cmd_valid_o, cmd_scrub_o, busy_o;
  logic [ROW_W-1:0] cmd_row_o;
  logic [CNT_W-1:0] refresh_cnt_o, promote_cnt_o;

  always #2.5 clk_i = ~clk_i;

  refresh_sched #(.ROWS(ROWS), .BASE_TICKS(BASE), .SCRUB_TICKS(SCRUB), .CNT_W(CNT_W)) dut (
    .clk_i, .rst_ni, .en_i, .tick_i, .slow_mult_i,
    .prof_we_i, .prof_row_i, .prof_slow_i,
    .ecc_err_i, .ecc_row_i,
    .cmd_valid_o, .cmd_ready_i, .cmd_row_o, .cmd_scrub_o,
    .busy_o, .refresh_cnt_o, .promote_cnt_o
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int ref_q[$];
  int scr_q[$];
  bit m_slow[ROWS];
  int m_ptr = 0, m_pass = 0, m_mult = 4, total = 0;
  int ref_acc = 0, prom_exp = 0, hs_cnt = 0;
  bit last_scrub = 0;
  bit prev_hold = 0, prev_kind = 0;
  int prev_row = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_mult(input int m);
    if (m < 4) return 4;
    if (m > 8) return 8;
    return m;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // driver: one tick, updates the reference model and pushes expected commands
  task automatic do_tick(input bit err, input int erow);
    @(posedge clk_i); #1;
    tick_i = 1'b1;
    ecc_err_i = err;
    ecc_row_i = erow[ROW_W-1:0];
    if (err) begin
      if (m_slow[erow]) prom_exp++;
      m_slow[erow] = 1'b0;
    end
    total++;
    if (total % SCRUB == 0)
      for (int r = 0; r < ROWS; r++) scr_q.push_back(r);
    if (total % SLOT == 0) begin
      if (!m_slow[m_ptr] || m_pass == 0) ref_q.push_back(m_ptr);
      if (m_ptr == ROWS - 1) begin
        m_ptr = 0;
        m_pass = (m_pass >= eff_mult(m_mult) - 1) ? 0 : m_pass + 1;
      end else begin
        m_ptr++;
      end
    end
    @(posedge clk_i); #1;
    tick_i = 1'b0;
    ecc_err_i = 1'b0;
  endtask

  task automatic load(input int row, input bit slow);
    @(posedge clk_i); #1;
    prof_we_i = 1'b1;
    prof_row_i = row[ROW_W-1:0];
    prof_slow_i = slow;
    if (!en_i) m_slow[row] = slow;
    @(posedge clk_i); #1;
    prof_we_i = 1'b0;
  endtask

  // monitor: compares every accepted command against the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk(busy_o == cmd_valid_o, "R9 busy", busy_o, cmd_valid_o);
      if (prev_hold)
        chk(cmd_valid_o && cmd_row_o == prev_row && cmd_scrub_o == prev_kind,
            "R8 held command", cmd_row_o, prev_row);
      prev_hold = cmd_valid_o && !cmd_ready_i;
      prev_row  = cmd_row_o;
      prev_kind = cmd_scrub_o;
      if (cmd_valid_o && cmd_ready_i) begin
        hs_cnt++;
        last_scrub = cmd_scrub_o;
        if (cmd_scrub_o) begin
          if (scr_q.size() == 0) chk(1'b0, "R6 unexpected scrub row", cmd_row_o, -1);
          else begin
            int e;
            e = scr_q.pop_front();
            chk(cmd_row_o == e, "R6 scrub row", cmd_row_o, e);
          end
        end else begin
          ref_acc++;
          if (ref_q.size() == 0) chk(1'b0, "R2/R3 unexpected refresh row", cmd_row_o, -1);
          else begin
            int e;
            e = ref_q.pop_front();
            chk(cmd_row_o == e, "R2 R3 R5 refresh row", cmd_row_o, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    for (int r = 0; r < ROWS; r++) m_slow[r] = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    // R1: during reset
    chk(cmd_valid_o == 1'b0, "R1 valid in reset", cmd_valid_o, 0);
    chk(busy_o == 1'b0, "R1 busy in reset", busy_o, 0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk(refresh_cnt_o == 0, "R1 refresh count", refresh_cnt_o, 0);
    chk(promote_cnt_o == 0, "R1 promote count", promote_cnt_o, 0);
    chk(cmd_valid_o == 1'b0, "R1 valid after reset", cmd_valid_o, 0);

    // R4: profile while disabled
    load(5, 1'b1);
    load(6, 1'b1);
    @(posedge clk_i); #1;
    en_i = 1'b1;
    // R4: ignored while enabled (row 0 keeps refreshing every pass)
    load(0, 1'b1);
    for (int i = 0; i < 39; i++) do_tick(1'b0, 0);

    // R7: stall port across a sweep start and the following slot
    repeat (4) @(posedge clk_i);
    #1;
    cmd_ready_i = 1'b0;
    for (int i = 0; i < 5; i++) do_tick(1'b0, 0);
    repeat (2) @(posedge clk_i);
    #1;
    begin
      int base;
      int guard;
      base = hs_cnt;
      guard = 0;
      cmd_ready_i = 1'b1;
      while (hs_cnt < base + 2 && guard < 40) begin
        @(negedge clk_i); #1;
        guard++;
      end
      chk(hs_cnt >= base + 2 && !last_scrub, "R7 refresh ahead of scrub", last_scrub, 0);
    end
    for (int i = 0; i < 120; i++) do_tick(1'b0, 0);

    // R5: promotion on the tick that closes a skipped slow slot
    begin
      int guard;
      guard = 0;
      while (!(((total + 1) % SLOT == 0) && m_slow[m_ptr] && m_pass != 0 &&
               (total % SCRUB) > 16) && guard < 400) begin
        do_tick(1'b0, 0);
        guard++;
      end
      chk(guard < 400, "R5 bypass slot found", guard, 0);
      do_tick(1'b1, m_ptr);
    end
    repeat (3) @(posedge clk_i);
    #1;
    chk(promote_cnt_o == prom_exp, "R5 promote count slow row", promote_cnt_o, prom_exp);
    // R5: report on a fast row is no promotion
    do_tick(1'b1, 0);
    repeat (3) @(posedge clk_i);
    #1;
    chk(promote_cnt_o == prom_exp, "R5 promote count fast row", promote_cnt_o, prom_exp);
    for (int i = 0; i < 64; i++) do_tick(1'b0, 0);

    // R3: reload profile, multiple 12 clamps to 8
    @(posedge clk_i); #1;
    en_i = 1'b0;
    load(5, 1'b1);
    load(3, 1'b1);
    slow_mult_i = 4'd12;
    m_mult = 12;
    @(posedge clk_i); #1;
    en_i = 1'b1;
    for (int i = 0; i < 256; i++) do_tick(1'b0, 0);

    // R3: multiple 2 clamps to 4
    slow_mult_i = 4'd2;
    m_mult = 2;
    for (int i = 0; i < 128; i++) do_tick(1'b0, 0);

    repeat (60) @(posedge clk_i);
    #1;
    chk(ref_q.size() == 0, "R2 refreshes outstanding", ref_q.size(), 0);
    chk(scr_q.size() == 0, "R6 scrub reads outstanding", scr_q.size(), 0);
    chk(refresh_cnt_o == ref_acc, "R10 refresh count", refresh_cnt_o, ref_acc);
    chk(promote_cnt_o == prom_exp, "R5 final promote count", promote_cnt_o, prom_exp);
    done = 1;
    summary();
  end

endmodule